// File: doc/BRIEF.md
# Task register with descriptor cache

This block keeps track of which task the processor is currently running. It has two parts. The first is a 16-bit selector that software can load and read back. The second is a hidden copy of the base address and byte limit of that task's state segment. Internal logic reads this copy so that it does not have to fetch the descriptor again on every access. Software cannot read the hidden copy.

A privileged load request carries a selector and the requester's privilege level. The block runs cheap checks on the selector first. If they pass, it fetches the 8-byte descriptor from the global descriptor table over a memory request/response port and checks its type and present bit. Only then does it write the selector, base and limit together. A store request returns the selector and nothing else. A task-switch port lets the task-switch logic replace the whole register in one cycle, with no checks.

Handshake rules:
- The load request port uses valid/ready. `ld_ready` is high only while the block is idle. A request made while the block is busy is dropped.
- `mem_req_valid` stays high, with `mem_req_addr` held steady, until the cycle in which `mem_req_ready` is high.
- The response side has no back-pressure. The block accepts `mem_rsp_valid` only while it is waiting for its own read, and ignores it at all other times.
- The store port has no back-pressure. It answers every request one cycle later.

Top module: `task_reg_cache`

## Requirements
- R1: After reset the selector, cached base and cached limit are zero, `cur_valid` is low and the block is idle (`ld_ready` high, `ld_busy` low).
- R2: A load accepted at privilege 0 whose selector and descriptor pass all checks behaves as follows:
  - it issues exactly one read at `gdt_base + 8*sel[15:3]`;
  - in the cycle the response is accepted, it writes the selector, base and limit and sets `cur_valid`;
  - `ld_done` pulses in the next cycle with fault code 0.
- R3: A load accepted while `ld_cpl` is not zero:
  - is refused with fault code 1;
  - issues no memory read and changes no state;
  - `ld_done` pulses in the cycle after acceptance.
- R4: A load whose selector fails a check ends with fault code 1, no memory read and no state change, with `ld_done` in the cycle after acceptance. The selector checks are:
  - the table-indicator bit (bit 2) is set;
  - the index `sel[15:3]` is zero;
  - `8*index+7` is greater than `gdt_limit`.
- R5: The descriptor is checked in this order, and either fault leaves the register unchanged:
  - If bits 44:40 are not `0_1001`, the load ends with fault code 1.
  - If the type is correct but the present bit (bit 47) is clear, the load ends with fault code 2.
- R6: The cached base is descriptor bits {63:56, 39:16}. The raw 20-bit limit is bits {51:48, 15:0}. When bit 55 is set, the cached limit is `raw*4096 + 4095`; when it is clear, the cached limit is the raw value.
- R7: A store request raises `st_rsp_valid` in the next cycle. `st_rsp_sel` carries the selector as it was in the request cycle. A store request is served at any time, including during a load, and never returns the base or the limit.
- R8: `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready`. A `mem_rsp_valid` that arrives while no read is outstanding has no effect.
- R9: While a load is in progress, `ld_ready` is low, `ld_busy` is high, and a new load request has no effect.
- R10: When `cur_valid` is high, a cycle with `ts_valid` replaces the selector, base and limit with `ts_sel`, `ts_base` and `ts_limit`, with no checks. When `cur_valid` is low, `ts_valid` is ignored. If a switch and a load commit fall in the same cycle, the switch wins.
- R11: The selector, `cur_base`, `cur_limit` and `cur_valid` change only on a load commit or an accepted switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gdt_base | input | 32 | Descriptor table base address |
| gdt_limit | input | 16 | Descriptor table byte limit |
| ld_valid | input | 1 | Load request valid |
| ld_ready | output | 1 | Load request accepted when high with ld_valid |
| ld_sel | input | 16 | Selector to load |
| ld_cpl | input | 2 | Privilege level of the requester |
| ld_busy | output | 1 | Load in progress |
| ld_done | output | 1 | One-cycle load completion pulse |
| ld_fault | output | 2 | Completion code: 0 ok, 1 protection fault, 2 not present |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 64 | Descriptor data |
| st_valid | input | 1 | Store (read selector) request |
| st_rsp_valid | output | 1 | Store response valid |
| st_rsp_sel | output | 16 | Returned selector |
| ts_valid | input | 1 | Task-switch replace strobe |
| ts_sel | input | 16 | New selector from task switch |
| ts_base | input | 32 | New base from task switch |
| ts_limit | input | 32 | New byte limit from task switch |
| cur_valid | output | 1 | Register holds a loaded task |
| cur_base | output | 32 | Cached base for internal consumers |
| cur_limit | output | 32 | Cached byte limit for internal consumers |

## Verification
The bench goes after the order of the checks. A design that fetches before it tests the selector shows up as an unexpected read on a table-indicator, null-index or past-limit selector. A design that tests the present bit before the type returns code 2 for a not-present busy segment instead of code 1. Boundary selectors sit exactly at the table limit and one entry past it. Descriptors are built with and without granularity, so a missing or misplaced limit scale shows up in `cur_limit`.

Stray responses, held read requests, repeated load requests while busy, and stores during a load are aimed at a design that samples its input at the wrong time or drops the old selector too early. A switch is issued while the register is invalid, and again in the same cycle as a commit, to catch a wrong priority between the two write paths.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int SEL_W       = 16;
  localparam int ADDR_W      = 32;
  localparam int DESC_W      = 64;
  localparam int GDT_LIM_W   = 16;
  localparam int IDX_W       = SEL_W - 3;
  localparam int RAW_LIM_W   = 20;
  localparam int GRAN_SHIFT  = 12;
  localparam logic [3:0] TSS32_AVAIL = 4'h9;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_NP   = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    LD_IDLE,
    LD_REQ,
    LD_WAIT,
    LD_FIN
  } ld_phase_e;
endpackage

// File: rtl/trc_sel_check.sv
module trc_sel_check
  import trc_pkg::*;
(
  input  logic [SEL_W-1:0]     sel,
  input  logic [GDT_LIM_W-1:0] gdt_limit,
  output logic                 sel_ok
);
  logic [IDX_W-1:0]     index;
  logic [GDT_LIM_W-1:0] entry_end;
  logic                 unused_rpl;

  assign index      = sel[SEL_W-1:3];
  assign entry_end  = GDT_LIM_W'({index, 3'b111});
  assign unused_rpl = ^sel[1:0];

  // table indicator must select the global table, null index is refused,
  // and the whole 8-byte entry must sit inside the table limit
  assign sel_ok = !sel[2] && (index != '0) && (entry_end <= gdt_limit);
endmodule

// File: rtl/trc_desc_check.sv
module trc_desc_check
  import trc_pkg::*;
#(
  parameter bit HONOR_GRAN = 1'b1
) (
  input  logic [DESC_W-1:0] desc,
  output logic              type_ok,
  output logic              present,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] limit
);
  logic [RAW_LIM_W-1:0] raw_lim;
  logic                 unused_bits;

  assign type_ok     = (desc[44] == 1'b0) && (desc[43:40] == TSS32_AVAIL);
  assign present     = desc[47];
  assign base        = {desc[63:56], desc[39:16]};
  assign raw_lim     = {desc[51:48], desc[15:0]};
  assign unused_bits = ^{desc[55:52], desc[46:45]};

  generate
    if (HONOR_GRAN) begin : g_gran
      always_comb begin
        if (desc[55]) limit = {raw_lim, {GRAN_SHIFT{1'b1}}};
        else          limit = ADDR_W'(raw_lim);
      end
    end else begin : g_bytes
      assign limit = ADDR_W'(raw_lim);
    end
  endgenerate
endmodule

// File: rtl/trc_load_ctrl.sv
module trc_load_ctrl
  import trc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [1:0]        ld_cpl,
  input  logic              sel_ok,
  output logic              ld_busy,
  output logic              ld_done,
  output logic [1:0]        ld_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic              desc_type_ok,
  input  logic              desc_present,
  output logic              commit,
  output logic [SEL_W-1:0]  pend_sel
);
  ld_phase_e         phase_q;
  fault_e            fault_q;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic              accept;
  logic              early_refuse;
  fault_e            desc_fault;

  assign accept       = ld_valid && (phase_q == LD_IDLE);
  assign early_refuse = (ld_cpl != 2'd0) || !sel_ok;

  always_comb begin
    if (!desc_type_ok)      desc_fault = FLT_GP;
    else if (!desc_present) desc_fault = FLT_NP;
    else                    desc_fault = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= LD_IDLE;
      fault_q <= FLT_NONE;
      sel_q   <= '0;
      addr_q  <= '0;
    end else begin
      unique case (phase_q)
        LD_IDLE: if (accept) begin
          sel_q  <= ld_sel;
          addr_q <= gdt_base + (ADDR_W'(ld_sel[SEL_W-1:3]) << 3);
          if (early_refuse) begin
            fault_q <= FLT_GP;
            phase_q <= LD_FIN;
          end else begin
            fault_q <= FLT_NONE;
            phase_q <= LD_REQ;
          end
        end
        LD_REQ:  if (mem_req_ready) phase_q <= LD_WAIT;
        LD_WAIT: if (mem_rsp_valid) begin
          fault_q <= desc_fault;
          phase_q <= LD_FIN;
        end
        LD_FIN:  phase_q <= LD_IDLE;
        default: phase_q <= LD_IDLE;
      endcase
    end
  end

  assign ld_ready      = (phase_q == LD_IDLE);
  assign ld_busy       = (phase_q != LD_IDLE);
  assign ld_done       = (phase_q == LD_FIN);
  assign ld_fault      = (phase_q == LD_FIN) ? fault_q : FLT_NONE;
  assign mem_req_valid = (phase_q == LD_REQ);
  assign mem_req_addr  = addr_q;
  assign commit        = (phase_q == LD_WAIT) && mem_rsp_valid && (desc_fault == FLT_NONE);
  assign pend_sel      = sel_q;

  // R8: an offered read stays put until taken
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R3: nonzero privilege is refused with a protection fault on the next cycle
  a_r3_priv_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready && (ld_cpl != 2'd0)) |=> (ld_done && (ld_fault == 2'd1)));

  // R4: a selector that fails its checks never reaches memory
  a_r4_no_read_bad_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready && !sel_ok) |=> !mem_req_valid);

  // R2: the read phase and the completion pulse never overlap
  a_r2_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req_valid, ld_done}));
endmodule

// File: rtl/trc_state.sv
module trc_state
  import trc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [SEL_W-1:0]  commit_sel,
  input  logic [ADDR_W-1:0] commit_base,
  input  logic [ADDR_W-1:0] commit_limit,
  input  logic              ts_valid,
  input  logic [SEL_W-1:0]  ts_sel,
  input  logic [ADDR_W-1:0] ts_base,
  input  logic [ADDR_W-1:0] ts_limit,
  input  logic              st_valid,
  output logic              st_rsp_valid,
  output logic [SEL_W-1:0]  st_rsp_sel,
  output logic              cur_valid,
  output logic [ADDR_W-1:0] cur_base,
  output logic [ADDR_W-1:0] cur_limit
);
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] lim_q;
  logic              valid_q;
  logic              ts_apply;

  assign ts_apply = ts_valid && valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      base_q  <= '0;
      lim_q   <= '0;
      valid_q <= 1'b0;
    end else if (ts_apply) begin
      sel_q  <= ts_sel;
      base_q <= ts_base;
      lim_q  <= ts_limit;
    end else if (commit) begin
      sel_q   <= commit_sel;
      base_q  <= commit_base;
      lim_q   <= commit_limit;
      valid_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_rsp_valid <= 1'b0;
      st_rsp_sel   <= '0;
    end else begin
      st_rsp_valid <= st_valid;
      st_rsp_sel   <= sel_q;
    end
  end

  assign cur_valid = valid_q;
  assign cur_base  = base_q;
  assign cur_limit = lim_q;

  // R11: contents move only through one of the two write paths
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit || ts_apply) |=> ($stable(sel_q) && $stable(base_q) && $stable(lim_q)));

  // R10: a switch cannot make an empty register valid
  a_r10_switch_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && !commit) |=> !valid_q);
endmodule

// File: rtl/task_reg_cache.sv
module task_reg_cache
  import trc_pkg::*;
#(
  parameter bit HONOR_GRAN = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    gdt_base,
  input  logic [GDT_LIM_W-1:0] gdt_limit,
  input  logic                 ld_valid,
  output logic                 ld_ready,
  input  logic [SEL_W-1:0]     ld_sel,
  input  logic [1:0]           ld_cpl,
  output logic                 ld_busy,
  output logic                 ld_done,
  output logic [1:0]           ld_fault,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [ADDR_W-1:0]    mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [DESC_W-1:0]    mem_rsp_data,
  input  logic                 st_valid,
  output logic                 st_rsp_valid,
  output logic [SEL_W-1:0]     st_rsp_sel,
  input  logic                 ts_valid,
  input  logic [SEL_W-1:0]     ts_sel,
  input  logic [ADDR_W-1:0]    ts_base,
  input  logic [ADDR_W-1:0]    ts_limit,
  output logic                 cur_valid,
  output logic [ADDR_W-1:0]    cur_base,
  output logic [ADDR_W-1:0]    cur_limit
);
  logic              sel_ok;
  logic              desc_type_ok;
  logic              desc_present;
  logic [ADDR_W-1:0] desc_base;
  logic [ADDR_W-1:0] desc_limit;
  logic              commit;
  logic [SEL_W-1:0]  pend_sel;

  trc_sel_check u_sel_check (
    .sel       (ld_sel),
    .gdt_limit (gdt_limit),
    .sel_ok    (sel_ok)
  );

  trc_desc_check #(.HONOR_GRAN(HONOR_GRAN)) u_desc_check (
    .desc    (mem_rsp_data),
    .type_ok (desc_type_ok),
    .present (desc_present),
    .base    (desc_base),
    .limit   (desc_limit)
  );

  trc_load_ctrl u_load_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .gdt_base      (gdt_base),
    .ld_valid      (ld_valid),
    .ld_ready      (ld_ready),
    .ld_sel        (ld_sel),
    .ld_cpl        (ld_cpl),
    .sel_ok        (sel_ok),
    .ld_busy       (ld_busy),
    .ld_done       (ld_done),
    .ld_fault      (ld_fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .desc_type_ok  (desc_type_ok),
    .desc_present  (desc_present),
    .commit        (commit),
    .pend_sel      (pend_sel)
  );

  trc_state u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit       (commit),
    .commit_sel   (pend_sel),
    .commit_base  (desc_base),
    .commit_limit (desc_limit),
    .ts_valid     (ts_valid),
    .ts_sel       (ts_sel),
    .ts_base      (ts_base),
    .ts_limit     (ts_limit),
    .st_valid     (st_valid),
    .st_rsp_valid (st_rsp_valid),
    .st_rsp_sel   (st_rsp_sel),
    .cur_valid    (cur_valid),
    .cur_base     (cur_base),
    .cur_limit    (cur_limit)
  );
endmodule

// File: tb/task_reg_cache_bench.sv
module task_reg_cache_bench;
  localparam logic [31:0] GDT_BASE = 32'h0001_0000;
  localparam logic [15:0] GDT_LIM  = 16'h007F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0, ld_ready, ld_busy, ld_done;
  logic [15:0] ld_sel = '0;
  logic [1:0]  ld_cpl = '0, ld_fault;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        st_valid = 1'b0, st_rsp_valid;
  logic [15:0] st_rsp_sel;
  logic        ts_valid;
  logic [15:0] ts_sel = '0;
  logic [31:0] ts_base = '0, ts_limit = '0;
  logic        cur_valid;
  logic [31:0] cur_base, cur_limit;

  // bench-side drive variables
  logic        ts_man = 1'b0, ts_with_rsp = 1'b0, stray_v = 1'b0;
  logic        rsp_v_drv = 1'b0;
  logic [63:0] rsp_d_drv = '0;
  logic [63:0] dtab [0:15];
  logic [31:0] exp_base [0:15];
  logic [31:0] exp_lim  [0:15];
  int          exp_kind [0:15];

  int checks = 0, errors = 0, cycles = 0;
  int stall_cfg = 0, rsp_lat = 1;
  bit running = 1'b0, finished = 1'b0;

  assign ts_valid      = ts_man || (ts_with_rsp && rsp_v_drv);
  assign mem_rsp_valid = rsp_v_drv || stray_v;
  assign mem_rsp_data  = stray_v ? dtab[2] : rsp_d_drv;

  always #5 clk = ~clk;

  task_reg_cache u_task_reg_cache (
    .clk(clk), .rst_n(rst_n), .gdt_base(GDT_BASE), .gdt_limit(GDT_LIM),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_sel(ld_sel), .ld_cpl(ld_cpl),
    .ld_busy(ld_busy), .ld_done(ld_done), .ld_fault(ld_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .st_valid(st_valid),
    .st_rsp_valid(st_rsp_valid), .st_rsp_sel(st_rsp_sel),
    .ts_valid(ts_valid), .ts_sel(ts_sel), .ts_base(ts_base), .ts_limit(ts_limit),
    .cur_valid(cur_valid), .cur_base(cur_base), .cur_limit(cur_limit)
  );

  function automatic logic [63:0] mk_desc(logic [31:0] b, logic [19:0] l,
                                          bit g, logic [3:0] t, bit s, bit p);
    return {b[31:24], g, 1'b1, 2'b00, l[19:16], p, 2'b00, s, t, b[23:16], b[15:0], l[15:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int          m_phase = 0, m_fault = 0, m_idx = 0;
  string       m_tag = "R2";
  logic [15:0] m_psel = '0, m_sel = '0, m_st_sel = '0;
  logic [31:0] m_addr = '0, m_base = '0, m_lim = '0;
  bit          m_valid = 0, m_st_v = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_fault = 0; m_sel = '0; m_base = '0; m_lim = '0;
      m_valid = 0; m_st_v = 0; m_st_sel = '0;
    end else begin
      bit ts_go, commit_go;
      ts_go = ts_valid && m_valid;
      commit_go = 0;
      m_st_sel = m_sel;
      m_st_v = st_valid;
      case (m_phase)
        0: if (ld_valid) begin
          m_psel = ld_sel;
          m_idx  = int'(ld_sel >> 3);
          m_addr = GDT_BASE + 32'(m_idx * 8);
          if (ld_cpl != 0) begin m_fault = 1; m_tag = "R3"; m_phase = 3; end
          else if (ld_sel[2] || m_idx == 0 || (m_idx * 8 + 7) > int'(GDT_LIM)) begin
            m_fault = 1; m_tag = "R4"; m_phase = 3;
          end else m_phase = 1;
        end
        1: if (mem_req_ready) m_phase = 2;
        2: if (mem_rsp_valid) begin
          m_fault = exp_kind[m_idx];
          m_tag = (m_fault == 0) ? "R2" : "R5";
          commit_go = (m_fault == 0);
          m_phase = 3;
        end
        default: m_phase = 0;
      endcase
      if (ts_go) begin
        m_sel = ts_sel; m_base = ts_base; m_lim = ts_limit;
      end else if (commit_go) begin
        m_sel = m_psel; m_base = exp_base[m_idx]; m_lim = exp_lim[m_idx]; m_valid = 1;
      end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && running && !finished) begin
      chk(ld_ready == (m_phase == 0), "R9", "ld_ready", 64'(ld_ready), 64'(m_phase == 0));
      chk(ld_busy == (m_phase != 0), "R9", "ld_busy", 64'(ld_busy), 64'(m_phase != 0));
      chk(ld_done == (m_phase == 3), m_tag, "ld_done", 64'(ld_done), 64'(m_phase == 3));
      if (m_phase == 3)
        chk(int'(ld_fault) == m_fault, m_tag, "ld_fault", 64'(ld_fault), 64'(m_fault));
      chk(mem_req_valid == (m_phase == 1), "R8", "mem_req_valid", 64'(mem_req_valid), 64'(m_phase == 1));
      if (m_phase == 1)
        chk(mem_req_addr == m_addr, "R2", "mem_req_addr", 64'(mem_req_addr), 64'(m_addr));
      chk(cur_valid == m_valid, "R11", "cur_valid", 64'(cur_valid), 64'(m_valid));
      chk(cur_base == m_base, "R6", "cur_base", 64'(cur_base), 64'(m_base));
      chk(cur_limit == m_lim, "R6", "cur_limit", 64'(cur_limit), 64'(m_lim));
      chk(st_rsp_valid == m_st_v, "R7", "st_rsp_valid", 64'(st_rsp_valid), 64'(m_st_v));
      if (m_st_v)
        chk(st_rsp_sel == m_st_sel, "R7", "st_rsp_sel", 64'(st_rsp_sel), 64'(m_st_sel));
    end
  end

  // ---------------- memory responder ----------------
  bit          hs_pend = 0;
  int          wcnt = 0, stall_left = 0;
  logic [31:0] paddr = '0;
  initial mem_req_ready = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      rsp_v_drv = 0; wcnt = 0; hs_pend = 0; mem_req_ready = 0; stall_left = stall_cfg;
    end else begin
      rsp_v_drv = 0;
      if (hs_pend) begin hs_pend = 0; wcnt = rsp_lat; end
      if (wcnt > 0) begin
        wcnt--;
        if (wcnt == 0) begin
          rsp_v_drv = 1;
          rsp_d_drv = dtab[(paddr - GDT_BASE) >> 3];
        end
      end
      mem_req_ready = mem_req_valid && (stall_left == 0);
      if (mem_req_valid && stall_left > 0) stall_left--;
      if (mem_req_ready) begin hs_pend = 1; paddr = mem_req_addr; stall_left = stall_cfg; end
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_idle();
    while (ld_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_load(input logic [15:0] sel, input logic [1:0] cpl);
    @(negedge clk);
    ld_valid = 1; ld_sel = sel; ld_cpl = cpl;
    @(negedge clk);
    ld_valid = 0;
    wait_idle();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      dtab[i] = '0; exp_base[i] = '0; exp_lim[i] = '0; exp_kind[i] = 1;
    end
    dtab[1]  = mk_desc(32'h1234_5678, 20'h00067, 0, 4'h9, 0, 1); exp_base[1]  = 32'h1234_5678; exp_lim[1]  = 32'h67;       exp_kind[1]  = 0;
    dtab[2]  = mk_desc(32'hA0B0_C0D0, 20'h00012, 1, 4'h9, 0, 1); exp_base[2]  = 32'hA0B0_C0D0; exp_lim[2]  = 32'h0001_2FFF; exp_kind[2]  = 0;
    dtab[3]  = mk_desc(32'h0000_1000, 20'h00067, 0, 4'hB, 0, 1); exp_kind[3] = 1;
    dtab[4]  = mk_desc(32'h0000_2000, 20'h00067, 0, 4'h9, 1, 1); exp_kind[4] = 1;
    dtab[5]  = mk_desc(32'h0000_3000, 20'h00067, 0, 4'h9, 0, 0); exp_kind[5] = 2;
    dtab[6]  = mk_desc(32'h0040_0000, 20'hFFFFF, 1, 4'h9, 0, 1); exp_base[6]  = 32'h0040_0000; exp_lim[6]  = 32'hFFFF_FFFF; exp_kind[6]  = 0;
    dtab[7]  = mk_desc(32'h0000_4000, 20'h00067, 0, 4'hB, 0, 0); exp_kind[7] = 1;
    dtab[15] = mk_desc(32'hCAFE_0000, 20'h001FF, 0, 4'h9, 0, 1); exp_base[15] = 32'hCAFE_0000; exp_lim[15] = 32'h1FF;       exp_kind[15] = 0;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(!cur_valid && cur_base == 0 && cur_limit == 0, "R1", "reset contents",
        {cur_base, cur_limit}, 64'h0);
    chk(ld_ready && !ld_busy, "R1", "reset idle", 64'({ld_ready, ld_busy}), 64'b10);
    running = 1;
    st_valid = 1; @(negedge clk); st_valid = 0;
    chk(st_rsp_valid && st_rsp_sel == 16'h0, "R1", "reset selector", 64'(st_rsp_sel), 64'h0);

    // R10: switch ignored while invalid
    ts_sel = 16'h0123; ts_base = 32'h5555_0000; ts_limit = 32'h77;
    ts_man = 1; @(negedge clk); ts_man = 0; @(negedge clk);
    chk(!cur_valid && cur_base == 0, "R10", "switch while invalid", 64'(cur_base), 64'h0);

    // R3: privilege refusal
    do_load(16'h0008, 2'd3);
    chk(!cur_valid, "R3", "no state after refusal", 64'(cur_valid), 64'h0);
    // R4: selector checks, including both sides of the limit boundary
    do_load(16'h000C, 2'd0);
    do_load(16'h0003, 2'd0);
    do_load(16'h0080, 2'd0);
    chk(!cur_valid, "R4", "no state after selector faults", 64'(cur_valid), 64'h0);
    // R5: descriptor faults
    do_load(16'h0018, 2'd0);
    do_load(16'h0020, 2'd0);
    do_load(16'h0028, 2'd0);
    do_load(16'h0038, 2'd0);
    chk(!cur_valid, "R5", "no state after descriptor faults", 64'(cur_valid), 64'h0);

    // R2 / R6: good loads, byte and page granularity, last table entry
    do_load(16'h0008, 2'd0);
    chk(cur_valid && cur_limit == 32'h67, "R2", "byte limit load", 64'(cur_limit), 64'h67);
    stall_cfg = 3; rsp_lat = 4;
    do_load(16'h0012, 2'd0);
    chk(cur_limit == 32'h0001_2FFF, "R6", "scaled limit", 64'(cur_limit), 64'h12FFF);
    stall_cfg = 0; rsp_lat = 1;
    do_load(16'h0078, 2'd0);
    chk(cur_base == 32'hCAFE_0000, "R4", "last entry accepted", 64'(cur_base), 64'hCAFE0000);

    // R9 / R7: repeated request while busy, store during a load
    stall_cfg = 2; rsp_lat = 3;
    @(negedge clk);
    ld_valid = 1; ld_sel = 16'h0030; ld_cpl = 0;
    @(negedge clk);
    ld_sel = 16'h0008; st_valid = 1;
    @(negedge clk);
    ld_valid = 0; st_valid = 0;
    chk(st_rsp_sel == 16'h0078, "R7", "store during load", 64'(st_rsp_sel), 64'h78);
    wait_idle();
    chk(cur_limit == 32'hFFFF_FFFF, "R9", "busy request ignored", 64'(cur_limit), 64'hFFFFFFFF);
    stall_cfg = 0; rsp_lat = 1;

    // R8: stray response while idle
    stray_v = 1; @(negedge clk); stray_v = 0; @(negedge clk);
    chk(cur_base == 32'h0040_0000, "R8", "stray response ignored", 64'(cur_base), 64'h400000);

    // R10: switch when valid, then switch colliding with a commit
    ts_sel = 16'h0048; ts_base = 32'h0BAD_0000; ts_limit = 32'h0000_0FFF;
    ts_man = 1; @(negedge clk); ts_man = 0; @(negedge clk);
    chk(cur_base == 32'h0BAD_0000, "R10", "switch applied", 64'(cur_base), 64'hBAD0000);
    ts_sel = 16'h0050; ts_base = 32'h0FEE_0000; ts_limit = 32'h1234;
    ts_with_rsp = 1;
    do_load(16'h0008, 2'd0);
    ts_with_rsp = 0;
    chk(cur_base == 32'h0FEE_0000, "R10", "switch wins over commit", 64'(cur_base), 64'hFEE0000);
    st_valid = 1; @(negedge clk); st_valid = 0;
    chk(st_rsp_sel == 16'h0050, "R7", "selector after switch", 64'(st_rsp_sel), 64'h50);

    // R11: a faulting load after valid state leaves everything intact
    do_load(16'h0028, 2'd0);
    chk(cur_base == 32'h0FEE_0000 && cur_limit == 32'h1234, "R11", "fault keeps contents",
        {cur_base, cur_limit}, {32'h0FEE_0000, 32'h1234});

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule